// File: doc/BRIEF.md
# Compressed Push/Pop Register Sequencer

This block carries out the compressed stack-frame instructions of a 64-bit core: push, pop, pop-and-return and pop-return-zero. On a start pulse it takes a 4-bit register-list code, a 2-bit stack-immediate field, an operation code and the current stack pointer. It then moves the selected saved registers between the register file and the stack, issuing one doubleword access per cycle on a request/ready memory port.

The register-list code is a count, not a bitmask. It walks a fixed, non-contiguous register order, and the stack frame size is rounded up to 16 bytes. After the last transfer, one final cycle writes the new stack pointer. The same cycle also redirects the PC to the restored return address for the return forms, and zeroes x10 for the return-zero form.

A reserved register-list code raises a one-cycle illegal flag and the block stays idle.

Top module: `pp_seq`

## Requirements
- R1: A start with register-list code 0..3 pulses `illegal_o` in the next cycle and does nothing else. It makes no memory request, sets no busy, writes no stack pointer, PC or register.
- R2: The list code selects N registers: code c in 4..14 gives N = c-3, and code 15 gives N = 13. Exactly N memory transfers are made.
- R3: Transfer i (i = 0..N-1) uses register number 1 for i=0, 8 for i=1, 9 for i=2, and 15+i for i>=3. Code 15 therefore covers x1, x8, x9 and x18..x27.
- R4: Push transfer i stores (`mem_we_o`=1) the value of the register from R3 to address sp - 8N + 8i. The last listed register therefore lands at sp - 8.
- R5: The frame adjustment is A = roundup16(8N) + 16*spimm (op code 0 = push, 1 = pop, 2 = pop-return, 3 = pop-return-zero). Push writes sp - A to the stack pointer.
- R6: For the pop forms (op 1..3), transfer i loads (`mem_we_o`=0) from sp + A - 8N + 8i and writes the loaded data into the register from R3.
- R7: The pop forms write sp + A to the stack pointer.
- R8: No register outside the selected list is written, and x10 keeps its value, except as stated in R10. Push and plain pop raise no PC write.
- R9: Pop-return and pop-return-zero write the PC with the value restored into x1 by the pop, not with the value x1 held before.
- R10: Pop-return-zero writes 0 to x10 in its final cycle.
- R11: `busy_o` rises the cycle after an accepted start and stays high through the final cycle. `done_o` is a one-cycle pulse coinciding with the stack-pointer write, after which the block is idle.
- R12: While `mem_ready_i` is low, the pending request keeps its address and direction unchanged.
- R13: A start pulse arriving while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| op_i | input | 2 | 0 push, 1 pop, 2 pop-return, 3 pop-return-zero |
| rlist_i | input | 4 | Register-list code |
| spimm_i | input | 2 | Extra stack adjustment in 16-byte units |
| sp_i | input | 64 | Stack pointer at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final-cycle pulse |
| illegal_o | output | 1 | Reserved list code seen |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | 64 | Byte address of the doubleword |
| mem_wdata_o | output | 64 | Store data |
| mem_ready_i | input | 1 | Transfer completes this cycle |
| mem_rdata_i | input | 64 | Load data, valid with ready |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 64 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 64 | Register-file write data |
| sp_we_o | output | 1 | Stack-pointer write |
| sp_o | output | 64 | New stack pointer |
| pc_we_o | output | 1 | PC redirect |
| pc_o | output | 64 | Redirect target |

## Verification
The bench sweeps every operation against every register-list code and every stack immediate, alternating between an always-ready memory and one that stalls two cycles in three. The full code range separates the reserved codes from legal ones and exposes any slip in the count table, including the double step at code 15. The immediate sweep separates the rounded base adjustment from the added term, and the four operations separate the store direction, the x10 handling and the PC redirect. Register and memory contents are seeded with distinct values, so a restored return address cannot be confused with the old one. A separate run fires a second start mid-sequence to show it is dropped.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_POPRET  = 2'd2,
    OP_POPRETZ = 2'd3
  } pp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } pp_st_e;

  localparam int MAX_REGS = 13;
  localparam int RA_W     = 5;
  localparam logic [RA_W-1:0] RA_REG  = 5'd1;
  localparam logic [RA_W-1:0] A0_REG  = 5'd10;

  // list slot -> architectural register
  function automatic logic [RA_W-1:0] slot_reg(int i);
    if (i == 0)     return RA_REG;
    else if (i < 3) return RA_W'(i + 7);
    else            return RA_W'(i + 15);
  endfunction

endpackage

// File: rtl/pp_seq_decode.sv
module pp_seq_decode #(
  parameter int XLEN  = 64,
  parameter int CNT_W = 4,
  parameter int ADJ_W = 9
) (
  input  logic [3:0]       rlist_i,
  input  logic [1:0]       spimm_i,
  output logic             legal_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ADJ_W-1:0] adj_o
);
  localparam int WB = XLEN / 8;

  logic [ADJ_W-1:0] bytes, base;

  always_comb begin
    legal_o = rlist_i >= 4'd4;
    if (!legal_o)              cnt_o = '0;
    else if (rlist_i == 4'd15) cnt_o = CNT_W'(13);
    else                       cnt_o = CNT_W'(rlist_i - 4'd3);
    bytes = ADJ_W'(cnt_o) * ADJ_W'(WB);
    base  = (bytes + ADJ_W'(15)) & ~ADJ_W'(15);
    adj_o = base + {{(ADJ_W-6){1'b0}}, spimm_i, 4'b0000};
  end

endmodule

// File: rtl/pp_seq_regsel.sv
module pp_seq_regsel #(
  parameter int MAX_REGS = pp_seq_pkg::MAX_REGS,
  parameter int IDX_W    = 4,
  parameter int RA_W     = pp_seq_pkg::RA_W
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [RA_W-1:0]  reg_o
);
  logic [RA_W-1:0] tbl [MAX_REGS];

  for (genvar g = 0; g < MAX_REGS; g++) begin : g_slot
    assign tbl[g] = RA_W'(pp_seq_pkg::slot_reg(g));
  end

  always_comb begin
    reg_o = '0;
    for (int k = 0; k < MAX_REGS; k++)
      if (idx_i == IDX_W'(k)) reg_o = tbl[k];
  end

endmodule

// File: rtl/pp_seq_agen.sv
module pp_seq_agen #(
  parameter int XLEN = 64,
  parameter int STEP = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            step_i,
  output logic [XLEN-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + XLEN'(STEP);
  end

endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_seq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [3:0]      rlist_i,
  input  logic [1:0]      spimm_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [4:0]      rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            sp_we_o,
  output logic [XLEN-1:0] sp_o,
  output logic            pc_we_o,
  output logic [XLEN-1:0] pc_o
);
  localparam int WB    = XLEN / 8;
  localparam int WB_SH = $clog2(WB);
  localparam int CNT_W = $clog2(MAX_REGS + 1);
  localparam int ADJ_W = $clog2(MAX_REGS * WB + 16 + 48) + 1;

  pp_st_e            st_q;
  pp_op_e            op_q, op_in;
  logic [CNT_W-1:0]  cnt_q, idx_q, cnt_d;
  logic [ADJ_W-1:0]  adj_d;
  logic [XLEN-1:0]   nsp_q, ra_q;
  logic              ill_q, legal_d;
  logic [RA_W-1:0]   cur_reg;
  logic [XLEN-1:0]   adj_x, frame_top, base_addr, agen_addr;
  logic              accept, is_push, xfer_hs, last_xfer;

  assign op_in = pp_op_e'(op_i);

  pp_seq_decode #(.XLEN(XLEN), .CNT_W(CNT_W), .ADJ_W(ADJ_W)) u_dec (
    .rlist_i (rlist_i),
    .spimm_i (spimm_i),
    .legal_o (legal_d),
    .cnt_o   (cnt_d),
    .adj_o   (adj_d)
  );

  pp_seq_regsel #(.MAX_REGS(MAX_REGS), .IDX_W(CNT_W), .RA_W(RA_W)) u_sel (
    .idx_i (idx_q),
    .reg_o (cur_reg)
  );

  assign accept    = start_i && (st_q == ST_IDLE);
  assign is_push   = (op_q == OP_PUSH);
  assign xfer_hs   = (st_q == ST_XFER) && mem_ready_i;
  assign last_xfer = (idx_q == cnt_q - CNT_W'(1));
  assign adj_x     = XLEN'(adj_d);
  assign frame_top = (op_in == OP_PUSH) ? sp_i : sp_i + adj_x;
  assign base_addr = frame_top - (XLEN'(cnt_d) << WB_SH);

  pp_seq_agen #(.XLEN(XLEN), .STEP(WB)) u_agen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && legal_d),
    .base_i (base_addr),
    .step_i (xfer_hs),
    .addr_o (agen_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_PUSH;
      cnt_q <= '0;
      idx_q <= '0;
      nsp_q <= '0;
      ra_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (!legal_d) begin
            ill_q <= 1'b1;
          end else begin
            op_q  <= op_in;
            cnt_q <= cnt_d;
            idx_q <= '0;
            nsp_q <= (op_in == OP_PUSH) ? sp_i - adj_x : sp_i + adj_x;
            st_q  <= ST_XFER;
          end
        end
        ST_XFER: if (mem_ready_i) begin
          // ra is always slot 0; keep the restored value for the redirect
          if (!is_push && idx_q == '0) ra_q <= mem_rdata_i;
          idx_q <= idx_q + CNT_W'(1);
          if (last_xfer) st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic fin;
  assign fin = (st_q == ST_FIN);

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = fin;
  assign illegal_o   = ill_q;
  assign mem_req_o   = (st_q == ST_XFER);
  assign mem_we_o    = (st_q == ST_XFER) && is_push;
  assign mem_addr_o  = agen_addr;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cur_reg;
  assign rf_we_o     = (xfer_hs && !is_push) || (fin && op_q == OP_POPRETZ);
  assign rf_waddr_o  = fin ? A0_REG : cur_reg;
  assign rf_wdata_o  = fin ? '0 : mem_rdata_i;
  assign sp_we_o     = fin;
  assign sp_o        = nsp_q;
  assign pc_we_o     = fin && (op_q == OP_POPRET || op_q == OP_POPRETZ);
  assign pc_o        = ra_q;

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !mem_req_o && !sp_we_o && !rf_we_o);

  // R11
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  // R4
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[WB_SH-1:0] == '0);

  // R8
  pc_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> sp_we_o && busy_o && !mem_req_o);

  // R10
  a0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && !mem_req_o |-> rf_waddr_o == A0_REG && rf_wdata_o == '0 && done_o);

endmodule

// File: tb/pp_seq_tb_top.sv
module pp_seq_tb_top;
  localparam logic [63:0] MEM_BASE = 64'h1000;
  localparam logic [63:0] SP0      = 64'h1200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  rlist_i = '0;
  logic [1:0]  spimm_i = '0;
  logic [63:0] sp_i = '0;
  logic        mem_ready_i = 1'b1;
  logic [63:0] mem_rdata_i, rf_rdata_i;
  logic        busy_o, done_o, illegal_o, mem_req_o, mem_we_o, rf_we_o, sp_we_o, pc_we_o;
  logic [63:0] mem_addr_o, mem_wdata_o, rf_wdata_o, sp_o, pc_o;
  logic [4:0]  rf_raddr_o, rf_waddr_o;

  always #10 clk = ~clk;

  logic [63:0] rf_m  [32];
  logic [63:0] mem_m [128];

  function automatic int widx(logic [63:0] a);
    return int'(((a - MEM_BASE) >> 3) & 64'd127);
  endfunction

  assign rf_rdata_i  = rf_m[rf_raddr_o];
  assign mem_rdata_i = mem_m[widx(mem_addr_o)];

  pp_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .rlist_i(rlist_i), .spimm_i(spimm_i), .sp_i(sp_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .sp_we_o(sp_we_o),
    .sp_o(sp_o), .pc_we_o(pc_we_o), .pc_o(pc_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  function automatic int nregs(int c);
    if (c < 4) return 0;
    if (c == 15) return 13;
    return c - 3;
  endfunction
  function automatic int adj_of(int c, int s);
    return ((nregs(c) * 8 + 15) / 16) * 16 + s * 16;
  endfunction
  function automatic int slot(int i);
    if (i == 0) return 1;
    if (i < 3) return i + 7;
    return i + 15;
  endfunction
  function automatic logic [63:0] init_val(int r);
    if (r == 0) return 64'h0;
    if (r == 10) return 64'hDEAD_BEEF;
    return 64'hA000_0000 + 64'(r);
  endfunction
  function automatic logic [63:0] pat(int w);
    return 64'h5000_0000 + 64'(w);
  endfunction

  // run state shared with the monitor
  int          cur_op;
  logic [63:0] exp_addr0;
  int          hs_cnt, done_cnt, sp_cnt, pc_cnt, req_seen, cyc;
  logic [63:0] sp_val, pc_val;
  bit          stall;

  always @(posedge clk) begin
    #1;
    cyc++;
    mem_ready_i = stall ? (cyc % 3 == 1) : 1'b1;
  end

  always @(negedge clk) if (rst_ni) begin
    if (mem_req_o) req_seen++;
    if (mem_req_o && mem_ready_i) begin
      chk(mem_addr_o == exp_addr0 + 64'(8 * hs_cnt),
          cur_op == 0 ? "R4 push address" : "R6 pop address",
          mem_addr_o, exp_addr0 + 64'(8 * hs_cnt));
      chk(mem_we_o == (cur_op == 0), "R4/R6 direction", 64'(mem_we_o), 64'(cur_op == 0));
      if (mem_we_o) mem_m[widx(mem_addr_o)] = mem_wdata_o;
      hs_cnt++;
    end
    if (rf_we_o) rf_m[rf_waddr_o] = rf_wdata_o;
    if (done_o) done_cnt++;
    if (sp_we_o) begin sp_cnt++; sp_val = sp_o; end
    if (pc_we_o) begin pc_cnt++; pc_val = pc_o; end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_one(int op, int rl, int spi, bit stl, bit poke);
    int n, adj, bad, t;
    logic [63:0] exp_sp, ev;
    bit in_list;
    n   = nregs(rl);
    adj = adj_of(rl, spi);
    for (int r = 0; r < 32; r++) rf_m[r] = init_val(r);
    for (int w = 0; w < 128; w++) mem_m[w] = pat(w);
    cur_op = op; stall = stl;
    hs_cnt = 0; done_cnt = 0; sp_cnt = 0; pc_cnt = 0; req_seen = 0;
    exp_sp    = (op == 0) ? SP0 - 64'(adj) : SP0 + 64'(adj);
    exp_addr0 = ((op == 0) ? SP0 : SP0 + 64'(adj)) - 64'(8 * n);
    step();
    start_i = 1'b1; op_i = 2'(op); rlist_i = 4'(rl); spimm_i = 2'(spi); sp_i = SP0;
    step();
    start_i = 1'b0;
    if (n == 0) begin
      chk(illegal_o == 1'b1, "R1 illegal flag", 64'(illegal_o), 64'd1);
      chk(busy_o == 1'b0, "R1 no busy", 64'(busy_o), 64'd0);
      repeat (4) step();
      chk(illegal_o == 1'b0, "R1 flag is a pulse", 64'(illegal_o), 64'd0);
      chk(req_seen == 0 && sp_cnt == 0 && pc_cnt == 0, "R1 no side effect",
          64'(req_seen + sp_cnt + pc_cnt), 64'd0);
      bad = 0;
      for (int r = 0; r < 32; r++) if (rf_m[r] != init_val(r)) bad++;
      chk(bad == 0, "R1 registers untouched", 64'(bad), 64'd0);
      return;
    end
    chk(busy_o == 1'b1, "R11 busy after start", 64'(busy_o), 64'd1);
    t = 0;
    while (done_cnt == 0 && t < 300) begin
      if (poke && t == 2) begin
        start_i = 1'b1; op_i = 2'd1; rlist_i = 4'd5; spimm_i = 2'd3; sp_i = SP0 + 64'h40;
      end else start_i = 1'b0;
      step(); t++;
    end
    start_i = 1'b0;
    repeat (3) step();
    chk(done_cnt == 1 && sp_cnt == 1, "R11 single done", 64'(done_cnt), 64'd1);
    chk(busy_o == 1'b0, "R11 idle after done", 64'(busy_o), 64'd0);
    chk(hs_cnt == n, poke ? "R13 restart ignored" : "R2 transfer count", 64'(hs_cnt), 64'(n));
    chk(sp_val == exp_sp, op == 0 ? "R5 push sp" : "R7 pop sp", sp_val, exp_sp);
    if (op == 0) begin
      bad = 0;
      for (int i = 0; i < n; i++)
        if (mem_m[widx(exp_addr0) + i] != init_val(slot(i))) bad++;
      chk(bad == 0, "R3 R4 stored values", 64'(bad), 64'd0);
      bad = 0;
      for (int r = 0; r < 32; r++) if (rf_m[r] != init_val(r)) bad++;
      chk(bad == 0, "R8 push leaves registers", 64'(bad), 64'd0);
      chk(pc_cnt == 0, "R8 push no pc", 64'(pc_cnt), 64'd0);
    end else begin
      bad = 0;
      for (int r = 0; r < 32; r++) begin
        in_list = 1'b0;
        ev = init_val(r);
        for (int i = 0; i < n; i++) if (slot(i) == r) begin
          in_list = 1'b1; ev = pat(widx(exp_addr0) + i);
        end
        if (r == 10 && op == 3) ev = 64'h0;
        if (rf_m[r] != ev) bad++;
        if (!in_list && r != 10 && rf_m[r] != ev) bad++;
      end
      chk(bad == 0, "R6 R8 register state", 64'(bad), 64'd0);
      ev = (op == 3) ? 64'h0 : 64'hDEAD_BEEF;
      chk(rf_m[10] == ev, op == 3 ? "R10 x10 zeroed" : "R8 x10 kept", rf_m[10], ev);
      if (op == 1) chk(pc_cnt == 0, "R8 pop no pc", 64'(pc_cnt), 64'd0);
      else chk(pc_cnt == 1 && pc_val == pat(widx(exp_addr0)), "R9 pc from restored ra",
               pc_val, pat(widx(exp_addr0)));
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_up();
  end

  initial begin
    stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    chk(!busy_o && !done_o && !illegal_o && !mem_req_o, "R11 reset state",
        64'({busy_o, done_o, illegal_o, mem_req_o}), 64'd0);
    for (int op = 0; op < 4; op++)
      for (int rl = 0; rl < 16; rl++)
        for (int spi = 0; spi < 4; spi++)
          run_one(op, rl, spi, ((rl + spi) % 2) == 1, 1'b0);
    run_one(0, 15, 1, 1'b0, 1'b1);  // R13
    run_one(2, 9, 2, 1'b1, 1'b1);   // R13 under stalls, R12
    finish_up();
  end

endmodule